// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block raises a periodic interrupt request toward a processor. A 32,768 Hz reference reaches it as a one-cycle enable pulse in the system clock domain. The block divides that reference by an 8-bit divisor that software writes through a small register port. A divisor of zero keeps the timer idle. Any nonzero value N gives one request for every N reference pulses. A value of 1 gives 32,768 requests per second and a value of 2 gives 16,384 per second.

The request is a level on an active-low output. It stays low until software makes an access, either a read or a write, to a dedicated acknowledge address. A new divisor takes effect at once: the write reloads the division counter, so the counter never has to run through its whole range and wrap before the new rate applies. If a period expires while a request is still waiting, the request stays low and a sticky overrun bit records the missed service. Software can read that bit back.

Register map, 2-bit address: 0 holds the divisor (read/write), 1 is status (read-only; bit 0 is overrun, bit 1 is pending), and 2 is the acknowledge access. Address 3 reads as zero.

Top module: `tick_irq_timer`

## Requirements
- R1: After reset the divisor reads 0, the status reads 0 and `irq_n` is high.
- R2: While the divisor is 0, no request is raised, however many reference pulses arrive.
- R3: With divisor N (1 to 255), `irq_n` goes low on the clock edge that takes the Nth reference pulse since the previous expiry or divisor write. Counting continues across that expiry, so requests repeat every N pulses.
- R4: Writing 0 to the divisor while the timer runs stops all further requests. A request that is already pending stays asserted.
- R5: A divisor write reloads the counter at once. The next request comes exactly N pulses after the write, whatever the old count was. A reference pulse in the same cycle as the write is not counted.
- R6: `irq_n` stays low until a read or a write to address 2. That access clears both pending and overrun. If a period expires in the same cycle as the acknowledge, the request stays asserted and overrun stays clear.
- R7: When a period expires while a request is pending and not being acknowledged, overrun (status bit 0) becomes 1 and stays 1 until the acknowledge. Status bit 1 reflects pending.
- R8: A read of address 0 returns the last value written there. A read of address 3 returns 0. Read data is combinational and valid in the cycle of the access.
- R9: The counter advances only on cycles where `tick_en` is high. Any number of cycles without it changes neither the request nor the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle enable pulse at the 32,768 Hz reference rate |
| bus_cs | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0 divisor, 1 status, 2 acknowledge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_n | output | 1 | Interrupt request, active low, held until acknowledged |

## Verification
The embedded assertions check the following on every cycle:
- while running, the count stays between 1 and the divisor, so it can never wrap;
- a divisor write lands in the counter on the next edge;
- a pending request survives every cycle without an acknowledge;
- an expiry on a pending request sets overrun;
- a zero divisor never starts a request.

Only the bench's scenarios can show the exact periods, measured as a number of reference pulses:
- for divisors of 1, 3 and 255;
- after a rewrite in mid-count;
- when a write and a pulse coincide.

The same holds for the coincidence of an expiry with an acknowledge, and for the read-back values of the register port.

// File: rtl/pit_pkg.sv
// Package: shared address map and status layout for the periodic
// interrupt timer. Assumes a 2-bit register address.
package pit_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_DIV  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_ACK  = 2'd2;

    // Status word: pending in bit 1, overrun in bit 0.
    typedef struct packed {
        logic pending;
        logic overrun;
    } pit_stat_t;

    localparam int STAT_W = $bits(pit_stat_t);

endpackage

// File: rtl/pit_divreg.sv
// Divisor register. Holds the software-written divisor and issues a
// reload strobe with the new value in the same cycle as the write.
// Assumes that wr_en is a single-cycle strobe from the bus decode.
module pit_divreg #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_data,
    output logic [DIV_W-1:0] div_q,
    output logic             load,
    output logic [DIV_W-1:0] load_val
);

    // Store the divisor; it resets to zero, which means idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (wr_en) begin
            div_q <= wr_data;
        end
    end

    // Pass the write straight on as a counter reload request.
    always_comb begin
        load     = wr_en;
        load_val = wr_data;
    end

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(div_q)); // R8

    AST_DIV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (div_q == $past(wr_data))); // R8

endmodule

// File: rtl/pit_divcnt.sv
// Division counter. Counts reference pulses down from the divisor and
// flags an expiry on the pulse that reaches the end of the period.
// Assumes that a reload always carries the value that the divisor
// register takes in the same cycle, so the count never exceeds the
// divisor.
module pit_divcnt #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    input  logic [DIV_W-1:0] div_q,
    output logic             expire
);

    localparam logic [DIV_W-1:0] CNT_LAST = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic             run;
    logic             at_last;

    // Decode whether the timer is enabled and at the final pulse of a period.
    always_comb begin
        run     = (div_q != '0);
        at_last = (cnt_q == CNT_LAST);
        expire  = tick_en && run && at_last && !load;
    end

    // Reload on a write; otherwise step on each reference pulse and
    // restart from the divisor at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick_en && run) begin
            if (at_last) begin
                cnt_q <= div_q;
            end else begin
                cnt_q <= cnt_q - CNT_LAST;
            end
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q != '0) |-> ((cnt_q != '0) && (cnt_q <= div_q))); // R5

    AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val))); // R5

    AST_CNT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load) |=> $stable(cnt_q)); // R9

    AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0) |-> !expire); // R2

endmodule

// File: rtl/pit_pending.sv
// Pending and overrun flags. Expiry sets pending. An acknowledge clears
// both flags. An expiry on an already pending, unacknowledged request
// sets the sticky overrun flag. Assumes that expire and ack are
// single-cycle strobes.
module pit_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ack,
    output logic pending,
    output logic overrun
);

    // Hold the request level; expiry takes priority over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (expire) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end

    // Record a period lost while a request was still waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (expire && pending && !ack) begin
            overrun <= 1'b1;
        end else if (ack) begin
            overrun <= 1'b0;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack) |=> pending); // R6

    AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pending); // R3

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && expire && !ack) |=> overrun); // R7

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !expire) |=> (!pending && !overrun)); // R6

    AST_OVR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> pending); // R7

endmodule

// File: rtl/tick_irq_timer.sv
// Programmable periodic interrupt timer, top level. Decodes the
// register port, wires the divisor register, the division counter and
// the pending flags together, and drives the active-low request.
// Assumes one access per bus_cs cycle and a tick_en pulse that is
// synchronous to clk.
module tick_irq_timer #(
    parameter int DIV_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_en,
    input  logic                      bus_cs,
    input  logic                      bus_we,
    input  logic [pit_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DIV_W-1:0]          bus_wdata,
    output logic [DIV_W-1:0]          bus_rdata,
    output logic                      irq_n
);

    import pit_pkg::*;

    localparam int PAD_W = DIV_W - STAT_W;

    logic             wr_div;
    logic             ack;
    logic [DIV_W-1:0] div_q;
    logic             load;
    logic [DIV_W-1:0] load_val;
    logic             expire;
    pit_stat_t        stat;

    // Decode divisor writes and acknowledge accesses (read or write).
    always_comb begin
        wr_div = bus_cs && bus_we && (bus_addr == ADDR_DIV);
        ack    = bus_cs && (bus_addr == ADDR_ACK);
    end

    pit_divreg #(.DIV_W(DIV_W)) u_divreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_div),
        .wr_data  (bus_wdata),
        .div_q    (div_q),
        .load     (load),
        .load_val (load_val)
    );

    pit_divcnt #(.DIV_W(DIV_W)) u_divcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load     (load),
        .load_val (load_val),
        .div_q    (div_q),
        .expire   (expire)
    );

    pit_pending u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .ack     (ack),
        .pending (stat.pending),
        .overrun (stat.overrun)
    );

    // Select read data for the addressed register.
    always_comb begin
        case (bus_addr)
            ADDR_DIV:  bus_rdata = div_q;
            ADDR_STAT: bus_rdata = {{PAD_W{1'b0}}, stat};
            default:   bus_rdata = '0;
        endcase
    end

    // Drive the request as an active-low level.
    always_comb begin
        irq_n = !stat.pending;
    end

    AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((div_q == '0) && irq_n && !wr_div) |=> irq_n); // R2

    AST_IRQ_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !ack) |=> !irq_n); // R6

endmodule

// File: tb/test_tick_irq_timer.sv
module test_tick_irq_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       bus_cs = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 0;
    bit finished = 0;

    // reference model state
    int m_div = 0;
    int m_elapsed = 0;
    bit m_pend = 0;
    bit m_ovr = 0;

    always #10 clk = ~clk;

    tick_irq_timer i_tick_irq_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_cs(bus_cs),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    // behavioural model: counts pulses elapsed since the last period start
    always @(posedge clk) begin
        bit is_ack;
        bit fire;
        if (!rst_n) begin
            m_div = 0; m_elapsed = 0; m_pend = 0; m_ovr = 0;
        end else begin
            is_ack = bus_cs && (bus_addr == 2'd2);
            fire = 0;
            if (bus_cs && bus_we && bus_addr == 2'd0) begin
                m_div = bus_wdata;
                m_elapsed = 0;
            end else if (tick_en && m_div != 0) begin
                m_elapsed++;
                if (m_elapsed >= m_div) begin
                    fire = 1;
                    m_elapsed = 0;
                end
            end
            if (fire) begin
                if (m_pend && !is_ack) m_ovr = 1;
                else if (is_ack) m_ovr = 0;
                m_pend = 1;
            end else if (is_ack) begin
                m_pend = 0;
                m_ovr = 0;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // every-cycle comparison of the request against the model (R3 R6)
    always @(negedge clk) begin
        if (cmp_en && !finished)
            check(irq_n === !m_pend, "R3 R6 per-cycle irq_n", int'(irq_n), int'(!m_pend));
    end

    task automatic step(input bit t, input bit cs, input bit we, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        tick_en = t; bus_cs = cs; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        tick_en = 0; bus_cs = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 2'd0, 8'd0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 2'd0, 8'd0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        step(0, 1, 1, a, d);
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        bus_cs = 1; bus_we = 0; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk);
        #1;
        bus_cs = 0; bus_addr = 0;
    endtask

    task automatic ticks_to_irq(input int maxn, output int n);
        n = 0;
        while (n < maxn) begin
            step(1, 0, 0, 2'd0, 8'd0);
            n++;
            if (!irq_n) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v;
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cmp_en = 1;

        // R1 reset state
        check(irq_n === 1'b1, "R1 irq_n after reset", int'(irq_n), 1);
        rd(2'd0, v); check(v == 0, "R1 divisor after reset", v, 0);
        rd(2'd1, v); check(v == 0, "R1 status after reset", v, 0);

        // R2 zero divisor stays idle
        ticks(20);
        check(irq_n === 1'b1, "R2 no request with divisor 0", int'(irq_n), 1);
        rd(2'd1, v); check(v == 0, "R2 status idle", v, 0);

        // R3 / R8 divisor 3
        wr(2'd0, 8'd3);
        rd(2'd0, v); check(v == 3, "R8 divisor read back", v, 3);
        ticks_to_irq(300, n); check(n == 3, "R3 period for N=3", n, 3);
        idle(5);
        check(irq_n === 1'b0, "R6 request held", int'(irq_n), 0);
        rd(2'd2, v);
        check(irq_n === 1'b1, "R6 ack by read clears", int'(irq_n), 1);
        ticks_to_irq(300, n); check(n == 3, "R3 repeat period N=3", n, 3);
        wr(2'd2, 8'd0);
        check(irq_n === 1'b1, "R6 ack by write clears", int'(irq_n), 1);

        // R9 gating
        idle(50);
        check(irq_n === 1'b1, "R9 no count without tick_en", int'(irq_n), 1);
        ticks_to_irq(300, n); check(n == 3, "R9 count unchanged by idle", n, 3);
        rd(2'd2, v);

        // R3 divisor 1 and 255
        wr(2'd0, 8'd1);
        ticks_to_irq(300, n); check(n == 1, "R3 period for N=1", n, 1);
        rd(2'd2, v);
        ticks_to_irq(300, n); check(n == 1, "R3 repeat for N=1", n, 1);
        rd(2'd2, v);
        wr(2'd0, 8'd255);
        ticks_to_irq(300, n); check(n == 255, "R3 period for N=255", n, 255);
        rd(2'd2, v);

        // R5 mid-count rewrite and coincident pulse
        wr(2'd0, 8'd10);
        ticks(6);
        wr(2'd0, 8'd4);
        ticks_to_irq(300, n); check(n == 4, "R5 rewrite mid-count", n, 4);
        rd(2'd2, v);
        step(1, 1, 1, 2'd0, 8'd5);
        ticks_to_irq(300, n); check(n == 5, "R5 pulse with write ignored", n, 5);
        rd(2'd2, v);

        // R7 overrun
        wr(2'd0, 8'd2);
        ticks(2);
        rd(2'd1, v); check(v == 2, "R7 pending without overrun", v, 2);
        ticks(2);
        rd(2'd1, v); check(v == 3, "R7 overrun set", v, 3);
        idle(3);
        rd(2'd1, v); check(v == 3, "R7 overrun sticky", v, 3);
        rd(2'd2, v);
        rd(2'd1, v); check(v == 0, "R6 ack clears overrun", v, 0);

        // R6 expiry coinciding with acknowledge
        wr(2'd0, 8'd2);
        ticks(2);
        ticks(1);
        step(1, 1, 0, 2'd2, 8'd0);
        rd(2'd1, v); check(v == 2, "R6 expiry wins over ack", v, 2);
        rd(2'd2, v);

        // R4 writing zero stops requests
        wr(2'd0, 8'd3);
        ticks(1);
        wr(2'd0, 8'd0);
        ticks(20);
        check(irq_n === 1'b1, "R4 stopped after zero write", int'(irq_n), 1);
        wr(2'd0, 8'd2);
        ticks(2);
        wr(2'd0, 8'd0);
        ticks(5);
        check(irq_n === 1'b0, "R4 pending kept after zero write", int'(irq_n), 0);
        rd(2'd1, v); check(v == 2, "R4 no overrun while stopped", v, 2);
        rd(2'd2, v);

        // R8 other address and read-back pattern
        rd(2'd3, v); check(v == 0, "R8 unused address reads 0", v, 0);
        wr(2'd0, 8'hA5);
        rd(2'd0, v); check(v == 8'hA5, "R8 read back pattern", v, 8'hA5);

        idle(2);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule